// File: doc/BRIEF.md
# Ten-Channel DMA Service Arbiter with Preemption

This block decides which DMA channel owns the transfer engine. Each channel offers a request line and an enable line; a channel is eligible while both are high. The arbiter keeps one channel in service at a time, reports its number on a 5-bit status output, and drives a one-hot grant vector. The grant is held until the transfer engine strobes `xfer_done_i`, and only then is the next channel chosen.

Two schemes are selectable with `mode_sw_i`. With the bit low, eligible channels are served in a rotating order, and a pulse on `prio_rst_i` restarts the rotation at channel 1. With the bit high, each channel's priority field is used. Levels 1 to 3 compete at transfer boundaries and the highest level wins. Level 0 marks an urgent channel, which takes the engine immediately. When it does, the interrupted channel's number is parked in a shadow status output. That channel is handed back once the urgent work has drained.

An emulation-halt input stops new grants once the running transfer completes, unless the free-run control is set. A hard-reset pulse returns the whole block to its idle state, as does the synchronous system reset.

Top module: `dma_svc_arbiter`

## Requirements
- R1: After `rst_i` or a `hard_rst_i` pulse, the next cycle shows `active_o` = 0, `shadow_o` = 0 and `grant_o` = 0. The rotation pointer restarts so that the next round-robin grant searches from channel 1.
- R2: `active_o` holds 0 (idle) or a channel number 1..10. `grant_o[i]` is high exactly when `active_o` = i+1.
- R3: With `mode_sw_i` = 0, a free slot goes to the first eligible channel after the one last granted in rotation, wrapping from channel 10 to channel 1. A slot is free when the block is idle or `xfer_done_i` is high. The new channel appears on the outputs one cycle later.
- R4: A `prio_rst_i` pulse makes the round-robin search in that cycle and later cycles start from channel 1 until the next rotating grant.
- R5: While a channel is in service and `xfer_done_i` is low, `active_o` does not change, except through R7.
- R6: With `mode_sw_i` = 1, a free slot goes to the eligible channel with the largest level among 1..3. Ties go to the lowest channel number. A channel's level is bits [1:0] of its 4-bit field in `prio_i` (channel n at bits [4n-1:4n-4]); bits [3:2] are ignored.
- R7: With `mode_sw_i` = 1, if the channel in service was not granted as a level-0 channel and another eligible channel has level 0, the next cycle shows `shadow_o` equal to the former `active_o` and `active_o` equal to the lowest-numbered such level-0 channel. A level-0 channel in service is never preempted.
- R8: When a slot frees in software mode and level-0 channels are pending, the lowest-numbered one is served next and `shadow_o` keeps its value. Otherwise a nonzero `shadow_o` is copied back into `active_o` and cleared to 0, ahead of any other choice and in either mode.
- R9: With `emu_halt_i` = 1 and `free_run_i` = 0, the channel in service keeps running. When it finishes, the block goes idle, and no grant, preemption or restore happens until the halt is released. With `free_run_i` = 1, the halt has no effect.
- R10: A channel whose enable is low is never newly granted, whatever its request line shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high system reset |
| hard_rst_i | input | 1 | Pulse that clears all arbitration state |
| req_i | input | 10 | Per-channel transfer request |
| en_i | input | 10 | Per-channel enable |
| mode_sw_i | input | 1 | 0 round-robin, 1 software priority |
| prio_i | input | 40 | Four bits per channel, channel 1 in bits [3:0] |
| prio_rst_i | input | 1 | Pulse restarting the rotation at channel 1 |
| xfer_done_i | input | 1 | Strobe: the channel in service finished its transfer |
| emu_halt_i | input | 1 | Emulation halt request |
| free_run_i | input | 1 | 1 ignores emulation halt |
| grant_o | output | 10 | One-hot grant of the channel in service |
| active_o | output | 5 | Channel in service, 0 when idle |
| shadow_o | output | 5 | Channel parked by a preemption, 0 when none |

## Verification
The bench builds the block with its defaults: ten channels, 4-bit priority fields, and 5-bit status. With these defaults every level-0 ordering, every wrap of the rotation past channel 10, and the reserved upper priority bits can be reached with random fields. A cycle-level reference model tracks the in-service channel, the parked channel, the rotation pointer and the urgent flag. Random mode, halt and enable patterns therefore exercise preemption while halted, a restore racing a new urgent request, and a rotation reset coinciding with a grant.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    // width of the channel-number status fields
    localparam int unsigned STAT_W = 5;
    // bits of a priority field that carry the arbitration level
    localparam int unsigned LVL_W  = 2;

    typedef logic [STAT_W-1:0] ch_id_t;
    typedef logic [LVL_W-1:0]  level_t;

    // outcome of one arbitration cycle
    typedef enum logic [2:0] {
        SEL_HOLD,
        SEL_IDLE,
        SEL_URGENT,
        SEL_RESTORE,
        SEL_NORMAL,
        SEL_PREEMPT
    } sel_e;

    typedef struct packed {
        ch_id_t active;
        ch_id_t shadow;
        logic   urgent;
    } svc_state_t;

    function automatic ch_id_t idx_to_id(input int unsigned idx);
        return ch_id_t'(idx + 1);
    endfunction

    function automatic logic is_urgent(input level_t lvl);
        return lvl == '0;
    endfunction

endpackage

// File: rtl/dma_arb_first_set.sv
module dma_arb_first_set #(
    parameter int unsigned NUM_CH = 10,
    parameter int unsigned IDX_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] vec_i,
    output logic              found_o,
    output logic [IDX_W-1:0]  idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
    parameter int unsigned NUM_CH = 10,
    parameter int unsigned IDX_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] elig_i,
    input  logic [IDX_W-1:0]  last_i,
    output logic              found_o,
    output logic [IDX_W-1:0]  idx_o
);
    // walk distances from far to near so the nearest eligible channel wins
    always_comb begin
        int unsigned c;
        found_o = 1'b0;
        idx_o   = '0;
        c       = 0;
        for (int k = NUM_CH; k >= 1; k--) begin
            c = (int'(last_i) + k) % NUM_CH;
            if (elig_i[c]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(c);
            end
        end
    end
endmodule

// File: rtl/dma_arb_level_pick.sv
module dma_arb_level_pick
    import dma_arb_pkg::*;
#(
    parameter int unsigned NUM_CH = 10,
    parameter int unsigned IDX_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]       elig_i,
    input  logic [NUM_CH*LVL_W-1:0] lvl_i,
    output logic                    found_o,
    output logic [IDX_W-1:0]        idx_o
);
    // downward scan with >= keeps the lowest index among equal levels
    always_comb begin
        level_t best;
        level_t cur;
        found_o = 1'b0;
        idx_o   = '0;
        best    = level_t'(1);
        cur     = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            cur = lvl_i[i*LVL_W +: LVL_W];
            if (elig_i[i] && !is_urgent(cur) && cur >= best) begin
                best    = cur;
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dma_svc_arbiter.sv
module dma_svc_arbiter
    import dma_arb_pkg::*;
#(
    parameter int unsigned NUM_CH = 10,
    parameter int unsigned PRIO_W = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     hard_rst_i,
    input  logic [NUM_CH-1:0]        req_i,
    input  logic [NUM_CH-1:0]        en_i,
    input  logic                     mode_sw_i,
    input  logic [NUM_CH*PRIO_W-1:0] prio_i,
    input  logic                     prio_rst_i,
    input  logic                     xfer_done_i,
    input  logic                     emu_halt_i,
    input  logic                     free_run_i,
    output logic [NUM_CH-1:0]        grant_o,
    output logic [STAT_W-1:0]        active_o,
    output logic [STAT_W-1:0]        shadow_o
);
    localparam int unsigned IDX_W    = $clog2(NUM_CH);
    localparam logic [IDX_W-1:0] PTR_RST = IDX_W'(NUM_CH - 1);

    svc_state_t          st_q, st_d;
    logic [IDX_W-1:0]    ptr_q, ptr_d, eff_ptr;
    sel_e                sel;

    logic [NUM_CH-1:0]       elig, urg_vec, urg_other, act_oh;
    logic [NUM_CH*LVL_W-1:0] lvl_flat;
    logic                    halted, slot_free;
    logic                    urg_found, oth_found, rr_found, lv_found;
    logic [IDX_W-1:0]        urg_idx, oth_idx, rr_idx, lv_idx;

    // per-channel level extraction and grant decode
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign lvl_flat[g*LVL_W +: LVL_W] = prio_i[g*PRIO_W +: LVL_W];
        assign urg_vec[g] = elig[g] && is_urgent(prio_i[g*PRIO_W +: LVL_W]);
        assign act_oh[g]  = (st_q.active == idx_to_id(g));
    end

    assign elig      = req_i & en_i;
    assign urg_other = urg_vec & ~act_oh;
    assign halted    = emu_halt_i && !free_run_i;
    assign slot_free = (st_q.active == '0) || xfer_done_i;
    assign eff_ptr   = prio_rst_i ? PTR_RST : ptr_q;

    dma_arb_first_set #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_urg_any (
        .vec_i(urg_vec), .found_o(urg_found), .idx_o(urg_idx)
    );

    dma_arb_first_set #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_urg_other (
        .vec_i(urg_other), .found_o(oth_found), .idx_o(oth_idx)
    );

    dma_arb_rr_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_rr (
        .elig_i(elig), .last_i(eff_ptr), .found_o(rr_found), .idx_o(rr_idx)
    );

    dma_arb_level_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_lvl (
        .elig_i(elig), .lvl_i(lvl_flat), .found_o(lv_found), .idx_o(lv_idx)
    );

    // decision for this cycle
    always_comb begin
        sel = SEL_HOLD;
        if (halted) begin
            sel = slot_free ? SEL_IDLE : SEL_HOLD;
        end else if (slot_free) begin
            if (mode_sw_i && urg_found)              sel = SEL_URGENT;
            else if (st_q.shadow != '0)              sel = SEL_RESTORE;
            else if (mode_sw_i ? lv_found : rr_found) sel = SEL_NORMAL;
            else                                     sel = SEL_IDLE;
        end else if (mode_sw_i && !st_q.urgent && oth_found) begin
            sel = SEL_PREEMPT;
        end
    end

    always_comb begin
        st_d  = st_q;
        ptr_d = eff_ptr;
        unique case (sel)
            SEL_IDLE: begin
                st_d.active = '0;
                st_d.urgent = 1'b0;
            end
            SEL_URGENT: begin
                st_d.active = idx_to_id(int'(urg_idx));
                st_d.urgent = 1'b1;
            end
            SEL_RESTORE: begin
                st_d.active = st_q.shadow;
                st_d.shadow = '0;
                st_d.urgent = 1'b0;
            end
            SEL_NORMAL: begin
                st_d.active = idx_to_id(int'(mode_sw_i ? lv_idx : rr_idx));
                st_d.urgent = 1'b0;
                if (!mode_sw_i) ptr_d = rr_idx;
            end
            SEL_PREEMPT: begin
                st_d.shadow = st_q.active;
                st_d.active = idx_to_id(int'(oth_idx));
                st_d.urgent = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || hard_rst_i) begin
            st_q  <= '{active: '0, shadow: '0, urgent: 1'b0};
            ptr_q <= PTR_RST;
        end else begin
            st_q  <= st_d;
            ptr_q <= ptr_d;
        end
    end

    assign grant_o  = act_oh;
    assign active_o = st_q.active;
    assign shadow_o = st_q.shadow;

    // ---------------- assertions ----------------
    assert_active_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        active_o <= STAT_W'(NUM_CH) && shadow_o <= STAT_W'(NUM_CH));

    assert_hard_clear_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        hard_rst_i |=> (active_o == '0 && shadow_o == '0 && grant_o == '0));

    assert_hold_rr_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!mode_sw_i && active_o != '0 && !xfer_done_i && !hard_rst_i) |=> $stable(active_o));

    assert_halt_idle_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (halted && active_o == '0 && !hard_rst_i) |=> (active_o == '0));

    assert_preempt_park_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_sw_i && !halted && active_o != '0 && !xfer_done_i && !st_q.urgent
         && oth_found && !hard_rst_i) |=> (shadow_o == $past(active_o)));

    assert_shadow_owner_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (shadow_o != '0) |-> (st_q.urgent || active_o == '0));

endmodule

// File: tb/tb_dma_svc_arbiter.sv
module tb_dma_svc_arbiter;
    localparam int N  = 10;
    localparam int PW = 4;

    logic            clk = 1'b0;
    logic            rst, hard_rst, mode_sw, prio_rst, xfer_done, emu_halt, free_run;
    logic [N-1:0]    req, en;
    logic [N*PW-1:0] prio;
    logic [N-1:0]    grant;
    logic [4:0]      active, shadow;

    int n_chk = 0, n_bad = 0;
    bit done_flag = 0;

    int m_act, m_sh, m_ptr;
    bit m_hp;

    always #10 clk = ~clk;

    dma_svc_arbiter dut (
        .clk_i(clk), .rst_i(rst), .hard_rst_i(hard_rst), .req_i(req), .en_i(en),
        .mode_sw_i(mode_sw), .prio_i(prio), .prio_rst_i(prio_rst),
        .xfer_done_i(xfer_done), .emu_halt_i(emu_halt), .free_run_i(free_run),
        .grant_o(grant), .active_o(active), .shadow_o(shadow)
    );

    task automatic check(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // reference model written from the requirement list
    task automatic model_next(output int na, output int ns, output int np, output bit nh);
        bit [N-1:0] el;
        bit halted, slot;
        int eptr, p0, pp, rr, sw, best, lvl, c;
        el = req & en;
        halted = emu_halt && !free_run;
        slot = (m_act == 0) || xfer_done;
        eptr = prio_rst ? N - 1 : m_ptr;
        p0 = -1; pp = -1; rr = -1; sw = -1; best = 0;
        for (int i = 0; i < N; i++) begin
            lvl = int'(prio[i*PW +: 2]);
            if (el[i] && mode_sw && lvl == 0) begin
                if (p0 < 0) p0 = i;
                if (i + 1 != m_act && pp < 0) pp = i;
            end
            if (el[i] && lvl != 0 && lvl > best) begin
                best = lvl; sw = i;
            end
        end
        for (int k = 1; k <= N; k++) begin
            c = (eptr + k) % N;
            if (el[c] && rr < 0) rr = c;
        end
        na = m_act; ns = m_sh; np = eptr; nh = m_hp;
        if (rst || hard_rst) begin
            na = 0; ns = 0; np = N - 1; nh = 0;
        end else if (halted) begin
            if (slot) begin na = 0; nh = 0; end
        end else if (slot) begin
            if (p0 >= 0) begin na = p0 + 1; nh = 1; end
            else if (m_sh != 0) begin na = m_sh; ns = 0; nh = 0; end
            else if (mode_sw ? (sw >= 0) : (rr >= 0)) begin
                na = (mode_sw ? sw : rr) + 1; nh = 0;
                if (!mode_sw) np = rr;
            end else begin na = 0; nh = 0; end
        end else if (mode_sw && !m_hp && pp >= 0) begin
            ns = m_act; na = pp + 1; nh = 1;
        end
    endtask

    task automatic step(string tag);
        int na, ns, np;
        bit nh;
        model_next(na, ns, np, nh);
        @(posedge clk);
        m_act = na; m_sh = ns; m_ptr = np; m_hp = nh;
        @(negedge clk);
        check({tag, " active"}, int'(active), m_act);
        check({tag, " shadow"}, int'(shadow), m_sh);
        check({tag, " grant"}, int'(grant), (m_act == 0) ? 0 : (1 << (m_act - 1)));
    endtask

    task automatic set_prio(int ch, logic [3:0] v);
        prio[(ch-1)*PW +: PW] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1; hard_rst = 0; mode_sw = 0; prio_rst = 0; xfer_done = 0;
        emu_halt = 0; free_run = 0; req = '0; en = '1;
        prio = {N{4'h1}};
        m_act = 0; m_sh = 0; m_ptr = N - 1; m_hp = 0;
        @(negedge clk); step("R1 reset"); step("R1 reset");
        rst = 0;
        check("R1 reset active", int'(active), 0);
        check("R1 reset grant", int'(grant), 0);

        // R3 rotation from channel 1
        req = '1;
        step("R3 first");           check("R3 first grant", int'(active), 1);
        xfer_done = 1;
        step("R3 rotate");          check("R3 second", int'(active), 2);
        step("R3 rotate");          check("R3 third", int'(active), 3);
        prio_rst = 1;
        step("R4 restart");         check("R4 restart at ch1", int'(active), 1);
        prio_rst = 0;
        en[1] = 0;
        step("R10 skip");           check("R10 disabled ch2 skipped", int'(active), 3);
        xfer_done = 0;
        step("R5 hold");            check("R5 held", int'(active), 3);
        step("R5 hold");            check("R5 held again", int'(active), 3);

        // R6 levels, ties and ignored upper bits
        en = '1; mode_sw = 1; xfer_done = 1;
        set_prio(2, 4'b0111); set_prio(5, 4'h3); set_prio(9, 4'b1110);
        step("R6 tie");             check("R6 tie lowest wins", int'(active), 2);
        req[1] = 0;
        step("R6 level");           check("R6 level3 ch5", int'(active), 5);

        // R7 preemption, R8 urgent order and restore
        xfer_done = 0; set_prio(8, 4'h0);
        step("R7 preempt");         check("R7 active urgent", int'(active), 8);
        check("R7 parked", int'(shadow), 5);
        set_prio(6, 4'b0100);
        step("R7 no urgent preempt"); check("R7 urgent kept", int'(active), 8);
        xfer_done = 1;
        step("R8 urgent order");    check("R8 next urgent ch6", int'(active), 6);
        check("R8 shadow kept", int'(shadow), 5);
        req[5] = 0; req[7] = 0;
        step("R8 restore");         check("R8 restored ch5", int'(active), 5);
        check("R8 shadow cleared", int'(shadow), 0);

        // R9 halt
        xfer_done = 0; emu_halt = 1; free_run = 0;
        step("R9 run on");          check("R9 transfer continues", int'(active), 5);
        xfer_done = 1;
        step("R9 stop");            check("R9 idle after done", int'(active), 0);
        xfer_done = 0;
        step("R9 held off");        check("R9 no new grant", int'(active), 0);
        free_run = 1;
        step("R9 free run");        check("R9 free run grants", int'(active), 5);

        // R1 hard reset
        hard_rst = 1;
        step("R1 hard");            check("R1 hard active", int'(active), 0);
        hard_rst = 0; emu_halt = 0; free_run = 0;

        // random phases: round-robin, software, mixed with halt
        for (int ph = 0; ph < 3; ph++) begin
            for (int cyc = 0; cyc < 500; cyc++) begin
                automatic logic [31:0] r = $urandom;
                if (cyc % 25 == 0)
                    for (int c = 0; c < N; c++) prio[c*PW +: PW] = 4'($urandom);
                req = N'($urandom | $urandom);
                en = ~N'($urandom & $urandom & $urandom);
                mode_sw = (ph == 0) ? 1'b0 : (ph == 1) ? 1'b1 : r[0];
                xfer_done = (r[3:2] == 2'b00);
                prio_rst = (r[9:5] == 5'd0);
                hard_rst = (r[17:10] == 8'd0);
                emu_halt = (ph == 2) && r[20];
                free_run = r[21];
                case (ph)
                    0: step("R3 R4 R10 random");
                    1: step("R6 R7 R8 random");
                    default: step("R9 R5 random");
                endcase
            end
        end

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule